// File: doc/BRIEF.md
# Interrupt Return and Return-Stack Unit

This block is the return path of a small 8-bit processor core. It watches the instruction word, recognises the two return instructions and carries them out. One is return-from-interrupt, which takes a fast-restore flag. The other is return-with-literal, which loads an 8-bit constant into the working register W. Both take the return address off a hardware LIFO and present it as the next program counter. A one-cycle flush slot follows each return, and any instruction offered in that slot is discarded.

The unit owns the W, STATUS and bank-select (BSR) registers and one shadow copy of each. The rest of the datapath writes these registers through a simple write strobe. On interrupt entry the return address is pushed and the live W, STATUS and BSR are copied into the shadows in the same cycle. A fast return copies them back. A two-entry record of the priority level being serviced decides which global interrupt-enable bit a return-from-interrupt sets again. In compatibility mode there is only one enable, carried on the high-priority output.

Top module: `ret_path_unit`

## Requirements
- R1: An instruction word with bits [15:1] = 000000000001000 (0x0010 or 0x0011) is a return-from-interrupt with fast flag s = bit 0. It pops the return stack, and the popped address appears on `pc_next` in the cycle after decode, while `flush` is high.
- R2: An instruction word with bits [15:8] = 0x0C is a return-with-literal. It pops the return stack like R1, and `w_out` equals bits [7:0] of the word in the cycle after decode.
- R3: `flush` is high for exactly the one cycle after each decoded return. A word offered while `flush` is high, a word with `instr_valid` low, and any other word cause no pop and no register change. `pc_next` holds its value between returns.
- R4: A return-from-interrupt with s=1 loads W, STATUS and BSR from their shadow copies. With s=0 it leaves them unchanged.
- R5: `push_req` with `push_irq`=1 is an interrupt entry. It pushes `push_addr` and copies the current W, STATUS and BSR into the shadows in the same cycle. A push with `push_irq`=0 is a call and leaves the shadows alone.
- R6: The return stack is LIFO, 31 entries of 21 bits. A push when all 31 entries are full is dropped.
- R7: A pop from the empty stack gives `pc_next` = 0, and `underflow` is high in the flush cycle.
- R8: In priority mode (`prio_mode`=1), a return-from-interrupt sets `gie_hi` if the level on top of the level record is high (1), and also sets `gie_hi` if the record is empty. It sets `gie_lo` if that level is low (0). In compatibility mode it sets `gie_hi`. The record is a two-entry LIFO: it is pushed with `irq_level` on interrupt entry, a push when it is full is dropped, and it is popped on return-from-interrupt.
- R9: In priority mode an interrupt entry clears `gie_hi` for a high level and `gie_lo` for a low level. In compatibility mode it clears `gie_hi`.
- R10: A return-with-literal changes neither enable bit, the level record nor the shadows.
- R11: `alu_we` loads `alu_w`, `alu_status` and `alu_bsr` in the next cycle. A return that writes W in the same cycle takes precedence over the ALU write.
- R12: If a push and a return fall in the same cycle, `pc_next` gets the old top and the pushed address replaces it. The shadows capture the pre-return register values while a fast restore loads the old shadows. If one enable bit is both set and cleared, the clear wins.
- R13: After reset, all outputs are 0, both stacks are empty and the shadows are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| push_req | input | 1 | Push `push_addr` onto the return stack |
| push_addr | input | 21 | Return address to push |
| push_irq | input | 1 | The push is an interrupt entry |
| irq_level | input | 1 | Priority of the entered interrupt, 1 = high |
| prio_mode | input | 1 | 1 = two priority levels, 0 = single enable |
| alu_we | input | 1 | Datapath write of W, STATUS, BSR |
| alu_w | input | 8 | W value from the datapath |
| alu_status | input | 5 | STATUS value from the datapath |
| alu_bsr | input | 4 | BSR value from the datapath |
| pc_next | output | 21 | Popped return address |
| flush | output | 1 | Flush slot; `pc_next` is fresh |
| underflow | output | 1 | The pop found the stack empty |
| w_out | output | 8 | W register |
| status_out | output | 5 | STATUS register |
| bsr_out | output | 4 | BSR register |
| gie_hi | output | 1 | High-priority (or single) global enable |
| gie_lo | output | 1 | Low-priority global enable |

## Verification
An interrupt entry can fall in the same cycle as a return-from-interrupt. In that cycle the unit pops and pushes the address stack and the level record, captures and restores the shadows, and both sets and clears enable bits. The bench drives a fast return, a high-priority entry and an ALU write in one cycle. It then issues a second fast return, which shows whether the shadows captured the pre-return values. A reference model in the bench steps along with the design every cycle and predicts all outputs. This model is what judges the overlap.

// File: rtl/ret_path_pkg.sv
package ret_path_pkg;
    parameter int ADDR_W    = 21;
    parameter int STK_DEPTH = 31;
    parameter int DATA_W    = 8;
    parameter int STAT_W    = 5;
    parameter int BSR_W     = 4;
    parameter int LVL_DEPTH = 2;
    parameter int INSTR_W   = 16;

    // bits [15:1] of return-from-interrupt, bits [15:8] of return-with-literal
    localparam logic [INSTR_W-2:0] OPC_RETI = 15'h0008;
    localparam logic [7:0]         OPC_RETL = 8'h0C;
endpackage

// File: rtl/ret_lifo.sv
// LIFO of DEPTH entries, AW bits wide.
// Push when full is dropped; pop when empty leaves it empty.
// Push and pop in one cycle replace the top (or fill slot 0 when empty).
// top_data reads 0 when empty. Assumes DEPTH >= 1.
module ret_lifo #(
    parameter int AW    = 21,
    parameter int DEPTH = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_data,
    output logic [AW-1:0] top_data,
    output logic          empty
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [CW-1:0] top_idx;
    logic [CW-1:0] wr_idx;
    logic          wr_en;
    logic          full;

    assign empty    = (cnt == '0);
    assign full     = (cnt == CW'(DEPTH));
    assign top_idx  = cnt - 1'b1;
    assign top_data = empty ? '0 : mem[top_idx];

    // Pick the slot written this cycle
    always_comb begin
        wr_en  = 1'b0;
        wr_idx = cnt;
        if (push && pop) begin
            wr_en  = 1'b1;
            wr_idx = empty ? '0 : top_idx;
        end else if (push && !full) begin
            wr_en  = 1'b1;
        end
    end

    // Occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push && pop) begin
            if (empty) cnt <= CW'(1);
        end else if (pop) begin
            if (!empty) cnt <= cnt - 1'b1;
        end else if (push && !full) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Entry storage, no reset needed
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= push_data;
    end
endmodule

// File: rtl/ret_decode.sv
// Combinational decode of the two return instructions.
// Assumes words are ignored while the flush slot is active.
module ret_decode
    import ret_path_pkg::*;
(
    input  logic               instr_valid,
    input  logic               in_flush,
    input  logic [INSTR_W-1:0] instr,
    output logic               is_reti,
    output logic               fast,
    output logic               is_retl,
    output logic [DATA_W-1:0]  literal
);
    logic live;

    // Qualify and match opcodes
    always_comb begin
        live    = instr_valid && !in_flush;
        is_reti = live && (instr[INSTR_W-1:1] == OPC_RETI);
        is_retl = live && (instr[INSTR_W-1:8] == OPC_RETL);
        fast    = instr[0];
        literal = instr[DATA_W-1:0];
    end
endmodule

// File: rtl/ret_ctx_regs.sv
// W, STATUS and BSR with one shadow copy each.
// Priority of the live registers: restore or literal over the datapath write.
// Capture always samples the values held before this edge.
module ret_ctx_regs #(
    parameter int DW = 8,
    parameter int SW = 5,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alu_we,
    input  logic [DW-1:0] alu_w,
    input  logic [SW-1:0] alu_status,
    input  logic [BW-1:0] alu_bsr,
    input  logic          lit_we,
    input  logic [DW-1:0] lit,
    input  logic          capture,
    input  logic          restore,
    output logic [DW-1:0] w_q,
    output logic [SW-1:0] st_q,
    output logic [BW-1:0] bsr_q,
    output logic [DW-1:0] sh_w,
    output logic [SW-1:0] sh_st,
    output logic [BW-1:0] sh_bsr
);
    // Live register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q   <= '0;
            st_q  <= '0;
            bsr_q <= '0;
        end else if (restore) begin
            w_q   <= sh_w;
            st_q  <= sh_st;
            bsr_q <= sh_bsr;
        end else begin
            if (alu_we) begin
                w_q   <= alu_w;
                st_q  <= alu_status;
                bsr_q <= alu_bsr;
            end
            if (lit_we) w_q <= lit;
        end
    end

    // Shadow capture on interrupt entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_w   <= '0;
            sh_st  <= '0;
            sh_bsr <= '0;
        end else if (capture) begin
            sh_w   <= w_q;
            sh_st  <= st_q;
            sh_bsr <= bsr_q;
        end
    end
endmodule

// File: rtl/ret_path_unit.sv
// Return path: decodes the returns, pops the address stack, restores
// context, re-arms the interrupt enables and raises a one-cycle flush.
// Assumes the fetch logic loads pc_next while flush is high.
module ret_path_unit
    import ret_path_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic               push_req,
    input  logic [ADDR_W-1:0]  push_addr,
    input  logic               push_irq,
    input  logic               irq_level,
    input  logic               prio_mode,
    input  logic               alu_we,
    input  logic [DATA_W-1:0]  alu_w,
    input  logic [STAT_W-1:0]  alu_status,
    input  logic [BSR_W-1:0]   alu_bsr,
    output logic [ADDR_W-1:0]  pc_next,
    output logic               flush,
    output logic               underflow,
    output logic [DATA_W-1:0]  w_out,
    output logic [STAT_W-1:0]  status_out,
    output logic [BSR_W-1:0]   bsr_out,
    output logic               gie_hi,
    output logic               gie_lo
);
    logic              is_reti, fast, is_retl, do_pop, irq_entry;
    logic [DATA_W-1:0] literal;
    logic [ADDR_W-1:0] stk_top;
    logic              stk_empty;
    logic              lvl_top, lvl_empty, srv_high;
    logic              set_hi, set_lo, clr_hi, clr_lo;
    logic [DATA_W-1:0] sh_w;
    logic [STAT_W-1:0] sh_st;
    logic [BSR_W-1:0]  sh_bsr;

    ret_decode u_dec (
        .instr_valid(instr_valid), .in_flush(flush), .instr(instr),
        .is_reti(is_reti), .fast(fast), .is_retl(is_retl), .literal(literal)
    );

    assign do_pop    = is_reti || is_retl;
    assign irq_entry = push_req && push_irq;

    ret_lifo #(.AW(ADDR_W), .DEPTH(STK_DEPTH)) u_addr_stk (
        .clk(clk), .rst_n(rst_n), .push(push_req), .pop(do_pop),
        .push_data(push_addr), .top_data(stk_top), .empty(stk_empty)
    );

    ret_lifo #(.AW(1), .DEPTH(LVL_DEPTH)) u_lvl_rec (
        .clk(clk), .rst_n(rst_n), .push(irq_entry), .pop(is_reti),
        .push_data(irq_level), .top_data(lvl_top), .empty(lvl_empty)
    );

    ret_ctx_regs #(.DW(DATA_W), .SW(STAT_W), .BW(BSR_W)) u_ctx (
        .clk(clk), .rst_n(rst_n),
        .alu_we(alu_we), .alu_w(alu_w), .alu_status(alu_status), .alu_bsr(alu_bsr),
        .lit_we(is_retl), .lit(literal),
        .capture(irq_entry), .restore(is_reti && fast),
        .w_q(w_out), .st_q(status_out), .bsr_q(bsr_out),
        .sh_w(sh_w), .sh_st(sh_st), .sh_bsr(sh_bsr)
    );

    // Decide which enable bit is re-armed or dropped
    always_comb begin
        srv_high = lvl_empty || lvl_top;
        set_hi   = is_reti && (!prio_mode || srv_high);
        set_lo   = is_reti && prio_mode && !srv_high;
        clr_hi   = irq_entry && (!prio_mode || irq_level);
        clr_lo   = irq_entry && prio_mode && !irq_level;
    end

    // Enable bits, clear beats set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_hi <= 1'b0;
            gie_lo <= 1'b0;
        end else begin
            if (clr_hi)      gie_hi <= 1'b0;
            else if (set_hi) gie_hi <= 1'b1;
            if (clr_lo)      gie_lo <= 1'b0;
            else if (set_lo) gie_lo <= 1'b1;
        end
    end

    // Next PC, flush slot and underflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_next   <= '0;
            flush     <= 1'b0;
            underflow <= 1'b0;
        end else begin
            flush     <= do_pop;
            underflow <= do_pop && stk_empty;
            if (do_pop) pc_next <= stk_top;
        end
    end
endmodule

// File: rtl/ret_path_unit_chk.sv
// Property checker for ret_path_unit, attached with bind below.
module ret_path_unit_chk
    import ret_path_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               instr_valid,
    input logic [INSTR_W-1:0] instr,
    input logic               push_req,
    input logic               alu_we,
    input logic [ADDR_W-1:0]  pc_next,
    input logic               flush,
    input logic               underflow,
    input logic [DATA_W-1:0]  w_out,
    input logic               gie_hi,
    input logic               gie_lo,
    input logic [DATA_W-1:0]  sh_w
);
    logic c_reti, c_retl, c_ret;
    assign c_reti = instr_valid && !flush && (instr[15:1] == 15'h0008);
    assign c_retl = instr_valid && !flush && (instr[15:8] == 8'h0C);
    assign c_ret  = c_reti || c_retl;

    assert_flush_after_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_ret |=> flush);
    assert_flush_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);
    assert_no_stray_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !c_ret |=> !flush);
    assert_literal_to_w_R2: assert property (@(posedge clk) disable iff (!rst_n)
        c_retl |=> (w_out == $past(instr[7:0])));
    assert_fast_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_reti && instr[0]) |=> (w_out == $past(sh_w)));
    assert_slow_keeps_w_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_reti && !instr[0] && !alu_we) |=> $stable(w_out));
    assert_underflow_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (flush && pc_next == '0));
    assert_reti_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_reti && !push_req) |=> (gie_hi || gie_lo));
    assert_retl_keeps_gie_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (c_retl && !push_req) |=> ($stable(gie_hi) && $stable(gie_lo)));
endmodule

bind ret_path_unit ret_path_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .push_req(push_req), .alu_we(alu_we), .pc_next(pc_next), .flush(flush),
    .underflow(underflow), .w_out(w_out), .gie_hi(gie_hi), .gie_lo(gie_lo),
    .sh_w(sh_w)
);

// File: tb/ret_path_unit_bench.sv
module ret_path_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        push_req = 1'b0;
    logic [20:0] push_addr = '0;
    logic        push_irq = 1'b0;
    logic        irq_level = 1'b0;
    logic        prio_mode = 1'b1;
    logic        alu_we = 1'b0;
    logic [7:0]  alu_w = '0;
    logic [4:0]  alu_status = '0;
    logic [3:0]  alu_bsr = '0;
    logic [20:0] pc_next;
    logic        flush, underflow, gie_hi, gie_lo;
    logic [7:0]  w_out;
    logic [4:0]  status_out;
    logic [3:0]  bsr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [20:0] mstk [32];
    int          mcnt = 0;
    logic        mlvl [2];
    int          lcnt = 0;
    logic [20:0] mpc = '0;
    logic        mflush = 0, muf = 0, mgh = 0, mgl = 0;
    logic [7:0]  mw = 0, sw = 0;
    logic [4:0]  mst = 0, sst = 0;
    logic [3:0]  mbsr = 0, sbsr = 0;

    always #2 clk = ~clk;

    ret_path_unit u_ret_path_unit (.*);

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        instr_valid = 0; instr = '0; push_req = 0; push_irq = 0;
        alu_we = 0; push_addr = '0; irq_level = 0;
    endtask

    // Advance the model one cycle, clock the design, compare every output
    task automatic tick(input string tag);
        logic rf, rl, pop, s, pirq, tophigh, sh, sl, ch, cl;
        logic [7:0] ow; logic [4:0] ost; logic [3:0] ob;
        rf = instr_valid && !mflush && (instr[15:1] == 15'h0008);
        rl = instr_valid && !mflush && (instr[15:8] == 8'h0C);
        pop = rf || rl; s = instr[0];
        pirq = push_req && push_irq;
        if (pop) begin
            mpc = (mcnt == 0) ? 21'd0 : mstk[mcnt-1];
        end
        muf = pop && (mcnt == 0);
        mflush = pop;
        if (push_req && pop) begin
            if (mcnt == 0) begin mstk[0] = push_addr; mcnt = 1; end
            else mstk[mcnt-1] = push_addr;
        end else if (pop) begin
            if (mcnt > 0) mcnt--;
        end else if (push_req && mcnt < 31) begin
            mstk[mcnt] = push_addr; mcnt++;
        end
        ow = mw; ost = mst; ob = mbsr;
        if (rf && s) begin mw = sw; mst = sst; mbsr = sbsr; end
        else begin
            if (alu_we) begin mw = alu_w; mst = alu_status; mbsr = alu_bsr; end
            if (rl) mw = instr[7:0];
        end
        if (pirq) begin sw = ow; sst = ost; sbsr = ob; end
        tophigh = (lcnt == 0) || mlvl[lcnt-1];
        sh = rf && (!prio_mode || tophigh);
        sl = rf && prio_mode && !tophigh;
        ch = pirq && (!prio_mode || irq_level);
        cl = pirq && prio_mode && !irq_level;
        if (pirq && rf) begin
            if (lcnt == 0) begin mlvl[0] = irq_level; lcnt = 1; end
            else mlvl[lcnt-1] = irq_level;
        end else if (rf) begin
            if (lcnt > 0) lcnt--;
        end else if (pirq && lcnt < 2) begin
            mlvl[lcnt] = irq_level; lcnt++;
        end
        if (ch) mgh = 0; else if (sh) mgh = 1;
        if (cl) mgl = 0; else if (sl) mgl = 1;
        @(posedge clk); #1;
        chk(tag, "pc_next", pc_next, mpc);
        chk(tag, "flush", flush, mflush);
        chk(tag, "underflow", underflow, muf);
        chk(tag, "w_out", w_out, mw);
        chk(tag, "status_out", status_out, mst);
        chk(tag, "bsr_out", bsr_out, mbsr);
        chk(tag, "gie_hi", gie_hi, mgh);
        chk(tag, "gie_lo", gie_lo, mgl);
        @(negedge clk);
    endtask

    task automatic alu(input logic [7:0] v, input string tag);
        alu_we = 1; alu_w = v; alu_status = v[4:0] ^ 5'h15; alu_bsr = v[7:4] ^ 4'h9;
        tick(tag); idle();
    endtask

    task automatic enter(input logic lvl, input logic [20:0] a, input string tag);
        push_req = 1; push_irq = 1; irq_level = lvl; push_addr = a;
        tick(tag); idle();
    endtask

    task automatic ret(input logic [15:0] op, input string tag);
        instr_valid = 1; instr = op; tick(tag); idle();
        tick(tag);
    endtask

    // Watchdog
    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        // R13: reset values
        chk("R13", "pc_next", pc_next, 0);
        chk("R13", "flush", flush, 0);
        chk("R13", "w_out", w_out, 0);
        chk("R13", "gie_hi", gie_hi, 0);
        chk("R13", "gie_lo", gie_lo, 0);
        rst_n = 1;

        // R11: datapath write
        alu(8'h3C, "R11");
        // R3: words that are not returns, or not valid
        foreach (instr[i]) begin end
        instr_valid = 1; instr = 16'h0012; tick("R3");
        instr = 16'h0D55; tick("R3");
        instr = 16'h0000; tick("R3");
        instr_valid = 0; instr = 16'h0011; tick("R3"); idle();

        // R6: fill 31 entries plus one dropped push (calls)
        for (int i = 0; i < 32; i++) begin
            push_req = 1; push_addr = 21'((i * 32'h0ABCD + 32'h155) & 32'h1FFFFF);
            tick("R6");
        end
        idle();
        // R2: unwind with literal returns, R3: word in flush slot ignored
        for (int i = 0; i < 31; i++) begin
            logic [7:0] k;
            k = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'((i * 37) & 255);
            instr_valid = 1; instr = {8'h0C, k}; tick("R2");
            instr = 16'h0C5A; tick("R3"); idle();
        end
        // R7: pops from an empty stack
        ret(16'h0C33, "R7");
        ret(16'h0010, "R7");

        // R5 / R4: shadow capture and both values of s
        for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 4; v++) begin
                alu(8'(v * 8'h45 + s + 1), "R11");
                enter(v[0], 21'(32'h1000 + v), "R5");
                push_req = 1; push_addr = 21'h0777; tick("R5"); idle();
                alu(8'(v * 8'h13 + 8'h80), "R11");
                ret(16'h0C11, "R10");
                ret(16'(16'h0010 | s), "R4");
            end
        end

        // R8 / R9: nested high over low, priority mode
        prio_mode = 1;
        ret(16'h0010, "R8");
        alu(8'h21, "R11");
        enter(1'b0, 21'h00A00, "R9");
        alu(8'h42, "R11");
        enter(1'b1, 21'h00B00, "R9");
        alu(8'h63, "R11");
        ret(16'h0011, "R1");
        ret(16'h0010, "R8");

        // R8 / R9: compatibility mode
        prio_mode = 0;
        enter(1'b0, 21'h01234, "R9");
        ret(16'h0010, "R8");
        enter(1'b1, 21'h01235, "R9");
        ret(16'h0011, "R1");
        prio_mode = 1;

        // R11: literal return and datapath write in one cycle
        push_req = 1; push_addr = 21'h1ABCD; tick("R6"); idle();
        instr_valid = 1; instr = 16'h0C9E; alu_we = 1; alu_w = 8'h55;
        alu_status = 5'h0A; alu_bsr = 4'h3; tick("R11"); idle(); tick("R11");

        // R12: entry, fast return and datapath write together
        alu(8'h11, "R11");
        enter(1'b0, 21'h0C000, "R12");
        alu(8'h22, "R11");
        instr_valid = 1; instr = 16'h0011; push_req = 1; push_irq = 1;
        irq_level = 1; push_addr = 21'h0D000; alu_we = 1; alu_w = 8'h99;
        tick("R12"); idle(); tick("R12");
        ret(16'h0011, "R12");
        ret(16'h0010, "R12");

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule